// File: doc/BRIEF.md
# Credit-Flow Controlled Link

This block connects a producer to a consumer across a long on-chip wire run. The wire run has a one-way latency of `LAT` cycles in each direction. Items travel forward through a chain of pipeline registers into a receive buffer of `DEPTH` entries. Each time the consumer takes an entry out of that buffer, a one-bit credit token travels back through a reverse register chain of the same latency. The sending side keeps a credit counter that starts at `DEPTH`. It accepts a new item only while at least one credit is available, so the receive buffer can never be overrun, even though the sender cannot see the buffer's fill level directly.

Both ends use a valid/ready handshake. On the producer side, `src_ready` means a credit is available. It counts a credit token that arrives in the same cycle. On the consumer side, `dst_valid` means the receive buffer is not empty. The depth must be at least twice the one-way latency. At that depth a consumer that is always ready sees one item per cycle, because the credit loop closes in exactly `2*LAT` cycles.

Top module: `credit_link`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `src_ready` is 1 and `dst_valid` is 0.
- R2: An item accepted in cycle c (both `src_valid` and `src_ready` high) appears on `dst_valid`/`dst_data` in cycle c+LAT when the receive buffer was empty, and not earlier.
- R3: The receive buffer never gets an arrival while it is full. The number of items accepted and not yet dequeued never exceeds `DEPTH`.
- R4: With the consumer stalled, the sender accepts exactly `DEPTH` items and then holds `src_ready` low. The credit count never exceeds `DEPTH`.
- R5: After a full-buffer stall, a dequeue in cycle p makes `src_ready` rise in cycle p+LAT, and not before.
- R6: While such a stall clears, the consumer sees `dst_valid` high for `DEPTH` consecutive cycles starting in the cycle its ready rises.
- R7: With `DEPTH` = 2*LAT (the smallest depth allowed, which elaboration enforces), a producer that is always valid and a consumer that is always ready move one item per cycle with no gaps.
- R8: Items leave in the order they were accepted, with unchanged data, under any pattern of valid and ready at the two ends.
- R9: A send and an arriving credit in the same cycle leave the credit count unchanged. The sum of held credits, buffered items, items in flight forward and credits in flight backward always equals `DEPTH`.
- R10: While `dst_valid` is high and `dst_ready` is low, `dst_valid` stays high and `dst_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Producer offers an item |
| src_data | input | DATA_W | Producer item payload |
| src_ready | output | 1 | A credit is available; the item is taken when valid is also high |
| dst_valid | output | 1 | Receive buffer holds at least one item |
| dst_data | output | DATA_W | Oldest buffered item |
| dst_ready | input | 1 | Consumer takes the oldest item when valid is also high |

## Verification
Each result has a fixed due cycle. An accepted item is due on the consumer side exactly LAT cycles after its accept cycle. A dequeue that ends a stall returns its credit to `src_ready` exactly LAT cycles later. A refilled item therefore reappears 2*LAT cycles after that dequeue. The bench numbers every cycle and samples one nanosecond after the rising edge, before it changes any input. It checks each output in the cycle just before the due cycle and in the due cycle itself, so a result that comes early and one that comes late both fail. Ordering and payload are checked separately by a scoreboard: accepted items are queued at the moment of acceptance and compared when the consumer takes them.

// File: rtl/cl_pkg.sv
package cl_pkg;

   // Number of bits needed to hold the values 0 .. max_val.
   function automatic int unsigned count_bits(int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

   // Index width for a storage of the given number of entries.
   function automatic int unsigned index_bits(int unsigned entries);
      return (entries < 2) ? 1 : $clog2(entries);
   endfunction

   // Circular increment for storages whose size need not be a power of two.
   function automatic int unsigned wrap_inc(int unsigned idx, int unsigned entries);
      return (idx + 1 >= entries) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/cl_delay_line.sv
module cl_delay_line #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [W-1:0]        in_data,
   output logic                out_valid,
   output logic [W-1:0]        out_data,
   output logic [(STAGES>0 ? STAGES : 1)-1:0] occ_vec
);

   generate
      if (STAGES == 0) begin : g_wire
         assign out_valid = in_valid;
         assign out_data  = in_data;
         assign occ_vec   = '0;
      end else begin : g_regs
         logic [STAGES-1:0] vld_q;
         logic [W-1:0]      dat_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= '0;
            end else begin
               vld_q[0] <= in_valid;
               for (int i = 1; i < STAGES; i++) begin
                  vld_q[i] <= vld_q[i-1];
               end
            end
         end

         // Payload registers load only with a valid beat to save toggles.
         always_ff @(posedge clk) begin
            if (in_valid) dat_q[0] <= in_data;
         end

         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
               if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
            end
         end

         assign out_valid = vld_q[STAGES-1];
         assign out_data  = dat_q[STAGES-1];
         assign occ_vec   = vld_q;
      end
   endgenerate

endmodule

// File: rtl/cl_credit_tx.sv
module cl_credit_tx #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned CW   = cl_pkg::count_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_valid,
   input  logic [W-1:0]  src_data,
   output logic          src_ready,
   input  logic          crd_in,
   output logic          lnk_valid,
   output logic [W-1:0]  lnk_data,
   output logic [CW-1:0] credits
);

   logic [CW-1:0] avail;
   logic          fire;

   // A credit arriving this cycle may be spent this cycle.
   assign avail     = credits + CW'(crd_in);
   assign src_ready = (avail != '0);
   assign fire      = src_valid & src_ready;
   assign lnk_valid = fire;
   assign lnk_data  = src_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         credits <= CW'(DEPTH);
      end else begin
         credits <= avail - CW'(fire);
      end
   end

endmodule

// File: rtl/cl_rx_buffer.sv
module cl_rx_buffer #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned AW   = cl_pkg::index_bits(DEPTH),
   localparam int unsigned CW   = cl_pkg::count_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   output logic          out_valid,
   output logic [W-1:0]  out_data,
   input  logic          out_ready,
   output logic          pop,
   output logic          full,
   output logic [CW-1:0] level
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_idx;
   logic [AW-1:0] rd_idx;

   assign out_valid = (level != '0);
   assign full      = (level == CW'(DEPTH));
   assign out_data  = mem[rd_idx];
   assign pop       = out_valid & out_ready;

   always_ff @(posedge clk) begin
      if (push) mem[wr_idx] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_idx <= '0;
         rd_idx <= '0;
         level  <= '0;
      end else begin
         if (push) wr_idx <= AW'(cl_pkg::wrap_inc(32'(wr_idx), DEPTH));
         if (pop)  rd_idx <= AW'(cl_pkg::wrap_inc(32'(rd_idx), DEPTH));
         level <= level + CW'(push) - CW'(pop);
      end
   end

endmodule

// File: rtl/credit_link.sv
module credit_link #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LAT    = 3,
   parameter int unsigned DEPTH  = 2 * LAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic              dst_valid,
   output logic [DATA_W-1:0] dst_data,
   input  logic              dst_ready
);

   // Forward: LAT-1 wire stages plus the buffer write make LAT cycles.
   localparam int unsigned FWD_ST = (LAT > 0) ? LAT - 1 : 0;
   localparam int unsigned FVW    = (FWD_ST > 0) ? FWD_ST : 1;
   // Reverse: LAT stages; the sender spends an arriving credit at once.
   localparam int unsigned REV_ST = LAT;
   localparam int unsigned RVW    = (REV_ST > 0) ? REV_ST : 1;
   localparam int unsigned CW     = cl_pkg::count_bits(DEPTH);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("credit_link: LAT must be at least 1");
      end
      if (DEPTH < 2 * LAT) begin : g_bad_depth
         $error("credit_link: DEPTH must be at least 2*LAT for full rate");
      end
   endgenerate

   logic              lnk_valid;
   logic [DATA_W-1:0] lnk_data;
   logic              fwd_valid;
   logic [DATA_W-1:0] fwd_data;
   logic [FVW-1:0]    fwd_occ;
   logic              rx_pop;
   logic              rx_full;
   logic [CW-1:0]     rx_level;
   logic              rev_valid;
   logic [0:0]        rev_tok;
   logic [RVW-1:0]    rev_occ;
   logic              crd_in;
   logic [CW-1:0]     tx_credits;

   assign crd_in = rev_valid & rev_tok[0];

   cl_credit_tx #(.W(DATA_W), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_data  (src_data),
      .src_ready (src_ready),
      .crd_in    (crd_in),
      .lnk_valid (lnk_valid),
      .lnk_data  (lnk_data),
      .credits   (tx_credits)
   );

   cl_delay_line #(.W(DATA_W), .STAGES(FWD_ST)) u_fwd (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (lnk_valid),
      .in_data   (lnk_data),
      .out_valid (fwd_valid),
      .out_data  (fwd_data),
      .occ_vec   (fwd_occ)
   );

   cl_rx_buffer #(.W(DATA_W), .DEPTH(DEPTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fwd_valid),
      .push_data (fwd_data),
      .out_valid (dst_valid),
      .out_data  (dst_data),
      .out_ready (dst_ready),
      .pop       (rx_pop),
      .full      (rx_full),
      .level     (rx_level)
   );

   cl_delay_line #(.W(1), .STAGES(REV_ST)) u_rev (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (rx_pop),
      .in_data   (1'b1),
      .out_valid (rev_valid),
      .out_data  (rev_tok),
      .occ_vec   (rev_occ)
   );

endmodule

// File: rtl/cl_link_checker.sv
module cl_link_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LAT    = 3,
   parameter int unsigned DEPTH  = 6,
   localparam int unsigned CW    = cl_pkg::count_bits(DEPTH),
   localparam int unsigned FVW   = (LAT > 1) ? LAT - 1 : 1,
   localparam int unsigned RVW   = (LAT > 0) ? LAT : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push,
   input logic              full,
   input logic              dst_valid,
   input logic              dst_ready,
   input logic [DATA_W-1:0] dst_data,
   input logic [CW-1:0]     credits,
   input logic [CW-1:0]     level,
   input logic [FVW-1:0]    fwd_occ,
   input logic [RVW-1:0]    rev_occ
);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   assert_credit_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      credits <= CW'(DEPTH));

   assert_credit_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(credits) + 32'(level) + $countones(fwd_occ) + $countones(rev_occ)) == DEPTH);

   assert_hold_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

endmodule

bind credit_link cl_link_checker #(.DATA_W(DATA_W), .LAT(LAT), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push      (fwd_valid),
   .full      (rx_full),
   .dst_valid (dst_valid),
   .dst_ready (dst_ready),
   .dst_data  (dst_data),
   .credits   (tx_credits),
   .level     (rx_level),
   .fwd_occ   (fwd_occ),
   .rev_occ   (rev_occ)
);

// File: tb/credit_link_test.sv
`timescale 1ns/1ps
module credit_link_test;
   localparam int N = 3;
   localparam int D = 2 * N;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic [W-1:0] src_data = 16'h0100;
   logic         src_ready;
   logic         dst_valid;
   logic [W-1:0] dst_data;
   logic         dst_ready = 1'b0;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int n_sent = 0;
   int n_recv = 0;
   int over_cnt = 0;
   bit done = 1'b0;
   logic [W-1:0] exp_q[$];
   logic [W-1:0] exp_item;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   credit_link #(.DATA_W(W), .LAT(N), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
      .src_ready(src_ready), .dst_valid(dst_valid), .dst_data(dst_data),
      .dst_ready(dst_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   // Monitor: scoreboard of accepted items against dequeued items (R8).
   always @(negedge clk) begin
      if (rst_n) begin
         if (dst_valid && dst_ready) begin
            n_recv++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected item", int'(dst_data), 0);
            end else begin
               exp_item = exp_q.pop_front();
               chk(dst_data === exp_item, "R8 order/data", int'(dst_data), int'(exp_item));
            end
         end
         if (src_valid && src_ready) begin
            exp_q.push_back(src_data);
            n_sent++;
         end
         if (n_sent - n_recv > D) over_cnt++;
      end
   end

   // One cycle: remember whether the producer handshake completes, cross
   // the edge, then present the next payload 1 ns later.
   task automatic step();
      bit fired;
      @(negedge clk);
      fired = src_valid && src_ready;
      @(posedge clk);
      #1;
      if (fired) src_data = src_data + 16'h0001;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == 20000 && !done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", cyc, 0);
         finish_run();
      end
   end

   initial begin
      int c0;
      int p;
      int s0;
      int r0;
      logic [W-1:0] d0;
      logic [7:0]   lfsr;

      // R1: reset state
      repeat (4) step();
      chk(src_ready === 1'b1, "R1 src_ready in reset", int'(src_ready), 1);
      chk(dst_valid === 1'b0, "R1 dst_valid in reset", int'(dst_valid), 0);
      rst_n = 1'b1;
      step();
      chk(src_ready === 1'b1, "R1 src_ready after reset", int'(src_ready), 1);
      chk(dst_valid === 1'b0, "R1 dst_valid after reset", int'(dst_valid), 0);

      // R2: single item, forward latency into an empty buffer
      d0 = src_data;
      src_valid = 1'b1;
      c0 = cyc;
      step();
      src_valid = 1'b0;
      while (cyc < c0 + N - 1) step();
      chk(dst_valid === 1'b0, "R2 item not early", int'(dst_valid), 0);
      step();
      chk(dst_valid === 1'b1, "R2 item due at c+LAT", int'(dst_valid), 1);
      chk(dst_data === d0, "R2 payload", int'(dst_data), int'(d0));

      // R4/R3/R10: stalled consumer, producer keeps offering
      src_valid = 1'b1;
      repeat (D + 2 * N + 2) step();
      chk(n_sent == D, "R4 accepted count under stall", n_sent, D);
      chk(n_sent - n_recv <= D, "R3 outstanding bound", n_sent - n_recv, D);
      chk(src_ready === 1'b0, "R4 src_ready low when out of credits", int'(src_ready), 0);
      chk(dst_data === d0, "R10 head held while stalled", int'(dst_data), int'(d0));

      // R5/R6: release the stall in cycle p
      p = cyc;
      dst_ready = 1'b1;
      for (int k = 0; k < D; k++) begin
         chk(dst_valid === 1'b1, "R6 drain continues", int'(dst_valid), 1);
         if (k == N - 1) chk(src_ready === 1'b0, "R5 credit not early", int'(src_ready), 0);
         if (k == N)     chk(src_ready === 1'b1, "R5 credit due at p+LAT", int'(src_ready), 1);
         step();
      end

      // R7/R9: full rate with DEPTH = 2*LAT
      s0 = n_sent;
      r0 = n_recv;
      repeat (40) step();
      chk(n_sent - s0 == 40, "R7 R9 one accept per cycle", n_sent - s0, 40);
      chk(n_recv - r0 == 40, "R7 one delivery per cycle", n_recv - r0, 40);

      // Drain and confirm everything arrived in order (R8)
      src_valid = 1'b0;
      repeat (3 * N + D + 4) step();
      chk(exp_q.size() == 0, "R8 all delivered", exp_q.size(), 0);
      chk(dst_valid === 1'b0, "R8 buffer empty", int'(dst_valid), 0);
      chk(src_ready === 1'b1, "R9 credits restored", int'(src_ready), 1);

      // R8/R3: irregular valid and ready patterns
      lfsr = 8'hA5;
      for (int i = 0; i < 400; i++) begin
         src_valid = lfsr[0];
         dst_ready = lfsr[3] | lfsr[5];
         step();
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      end
      src_valid = 1'b0;
      dst_ready = 1'b1;
      repeat (3 * N + D + 4) step();
      chk(n_sent == n_recv, "R8 mixed pattern count", n_recv, n_sent);
      chk(over_cnt == 0, "R3 never more than DEPTH outstanding", over_cnt, 0);

      // R2: latency with consumer always ready; visible for one cycle
      d0 = src_data;
      src_valid = 1'b1;
      c0 = cyc;
      step();
      src_valid = 1'b0;
      while (cyc < c0 + N) step();
      chk(dst_valid === 1'b1 && dst_data === d0, "R2 ready consumer sees item", int'(dst_data), int'(d0));
      step();
      chk(dst_valid === 1'b0, "R2 single item consumed", int'(dst_valid), 0);

      done = 1'b1;
      finish_run();
   end

endmodule